// File: doc/BRIEF.md
# Fractional-Rate Nanosecond Time Counter

This block is a free-running hardware clock for precision time protocols. Its clock input is the 8 ns reference. While the timer is running, every edge adds a fixed 8 ns step to a 40-bit nanosecond count. Below that count sits a 32-bit sub-nanosecond accumulator. A signed fractional correction is added to it or taken from it on every tick. When the accumulator overflows, that tick adds 9 ns instead of 8. When it underflows, the tick adds 7 ns. Software can therefore trim the clock rate in steps of 2^-32 ns per tick without changing the nominal step.

Software reaches the block through a small register bus with one access per cycle. Read data appears one cycle after the request. Reading the sub-nanosecond word returns the live accumulator and freezes a copy of the whole nanosecond count. The two nanosecond words then return that frozen copy, so a multi-word read is coherent. Writing the nanosecond-low word stages a value, and writing the high word loads the full count at once.

The timer is governed by a two-state machine with states `TS_HALTED` and `TS_RUNNING`:
- START moves the state from `TS_HALTED` to `TS_RUNNING`. It fires on a write to the auxiliary register with bit 31 clear.
- STOP moves the state from `TS_RUNNING` to `TS_HALTED`. It fires on a write to that register with bit 31 set.
- In all other cycles the state holds.

Register map (3-bit word address):
- 0 holds the trim.
- 1 is the auxiliary control register.
- 2 is the sub-nanosecond word.
- 3 is the nanosecond-low word.
- 4 is the high word.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the trim register reads 0, the auxiliary register (address 1) reads 0x8000_0000 (halted), and the count, the accumulator and both nanosecond words read 0.
- R2: While halted, the count and the accumulator do not change. A write to address 1 with bit 31 clear starts ticking from the following edge, and a write with bit 31 set stops it from the following edge. Bits 30:0 of address 1 always read 0.
- R3: While running with a zero trim magnitude, the count rises by exactly 8 per clock and the accumulator holds its value.
- R4: The trim (address 0) is split into a sign in bit 31 and a magnitude in bits 30:0. With bit 31 = 0 the magnitude is added to the 32-bit accumulator each tick, and a carry out makes that tick's step 9.
- R5: With bit 31 = 1 the magnitude is subtracted from the accumulator each tick, and a borrow makes that tick's step 7.
- R6: A read of address 2 returns the live accumulator and captures the count. Reads of address 3 return the captured bits 31:0, and reads of address 4 return the captured bits 39:32 in bits 7:0 with bits 31:8 zero. The capture stays unchanged until the next read of address 2.
- R7: A write to address 3 stages a low word. A write to address 4 loads the count with {wdata[7:0], staged word} on that edge and clears the accumulator, whether the timer is halted or running. No tick is added on that edge, and wdata[31:8] is ignored.
- R8: The count wraps from 2^40-1 to 0 with no other effect.
- R9: Read data appears on the edge after the request and holds until the next read. Writes to address 2 and to addresses 5–7 change nothing, and reads of addresses 5–7 return 0.
- R10: A read of address 0 returns the last value written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 ns reference clock; each edge is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cur_ns | output | 40 | Live nanosecond count |

## Verification
Two pairs of functions can fall on the same edge.

The first pair is a high-word load and a tick. The bench writes address 4 while the timer runs. The count must then equal the loaded value exactly on the next sample, with no 8 ns added, and the accumulator must restart from zero.

The second pair is a snapshot capture and a tick that carries or borrows. The bench reads address 2 repeatedly under positive, negative and near-maximum trims. The captured count must be the value from before that edge's tick.

A behavioural model in the bench judges both cases. It is written with plain integers and compares the count and the read data against the design on every clock.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned FRAC_W = 32;
    localparam int unsigned MAG_W  = DATA_W - 1;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_TRIM  = 3'd0,
        RA_AUX   = 3'd1,
        RA_SUBNS = 3'd2,
        RA_NSLO  = 3'd3,
        RA_NSHI  = 3'd4
    } reg_addr_e;

    typedef enum logic [0:0] {
        TS_HALTED  = 1'b0,
        TS_RUNNING = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } trim_t;
endpackage

// File: rtl/ptp_tc_ctrl_fsm.sv
module ptp_tc_ctrl_fsm
    import ptp_tc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic aux_wr,
    input  logic aux_halt,
    output logic tick_en,
    output logic halted
);
    tmr_state_e state_q;
    tmr_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_HALTED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: START and STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_HALTED: begin
                if (aux_wr && !aux_halt) begin
                    state_d = TS_RUNNING;
                end
            end
            TS_RUNNING: begin
                if (aux_wr && aux_halt) begin
                    state_d = TS_HALTED;
                end
            end
            default: state_d = TS_HALTED;
        endcase
    end

    // outputs
    always_comb begin
        tick_en = 1'b0;
        halted  = 1'b1;
        unique case (state_q)
            TS_RUNNING: begin
                tick_en = 1'b1;
                halted  = 1'b0;
            end
            default: begin
                tick_en = 1'b0;
                halted  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ptp_tc_frac_step.sv
module ptp_tc_frac_step
    import ptp_tc_pkg::*;
#(
    parameter int unsigned NS_W     = 40,
    parameter int unsigned NOM_STEP = 8
) (
    input  logic [FRAC_W-1:0] acc_q,
    input  trim_t             trim,
    output logic [FRAC_W-1:0] acc_d,
    output logic [NS_W-1:0]   step
);
    localparam int unsigned PAD_W = FRAC_W + 1 - MAG_W;

    logic [FRAC_W:0] mag_x;
    logic [FRAC_W:0] sum;
    logic            over;

    assign mag_x = {{PAD_W{1'b0}}, trim.mag};

    always_comb begin
        if (trim.neg) begin
            sum = {1'b0, acc_q} - mag_x;
        end else begin
            sum = {1'b0, acc_q} + mag_x;
        end
        over  = sum[FRAC_W];
        acc_d = sum[FRAC_W-1:0];
        if (!over) begin
            step = NS_W'(NOM_STEP);
        end else if (trim.neg) begin
            step = NS_W'(NOM_STEP - 1);
        end else begin
            step = NS_W'(NOM_STEP + 1);
        end
    end
endmodule

// File: rtl/ptp_tc_time_core.sv
module ptp_tc_time_core
    import ptp_tc_pkg::*;
#(
    parameter int unsigned NS_W     = 40,
    parameter int unsigned NOM_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              load,
    input  logic [NS_W-1:0]   load_val,
    input  trim_t             trim,
    output logic [NS_W-1:0]   ns_cnt,
    output logic [FRAC_W-1:0] frac_acc
);
    logic [FRAC_W-1:0] acc_nxt;
    logic [NS_W-1:0]   step;

    ptp_tc_frac_step #(
        .NS_W     (NS_W),
        .NOM_STEP (NOM_STEP)
    ) u_step (
        .acc_q (frac_acc),
        .trim  (trim),
        .acc_d (acc_nxt),
        .step  (step)
    );

    // load has priority over the tick of the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ns_cnt   <= '0;
            frac_acc <= '0;
        end else if (load) begin
            ns_cnt   <= load_val;
            frac_acc <= '0;
        end else if (tick_en) begin
            ns_cnt   <= ns_cnt + step;
            frac_acc <= acc_nxt;
        end
    end
endmodule

// File: rtl/ptp_tc_regbank.sv
module ptp_tc_regbank
    import ptp_tc_pkg::*;
#(
    parameter int unsigned NS_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NS_W-1:0]   ns_cnt,
    input  logic [FRAC_W-1:0] frac_acc,
    input  logic              halted,
    output trim_t             trim,
    output logic              aux_wr,
    output logic              aux_halt,
    output logic              load,
    output logic [NS_W-1:0]   load_val
);
    localparam int unsigned HI_W = NS_W - DATA_W;

    logic              wr;
    logic              rd;
    logic [DATA_W-1:0] stage_lo;
    logic [NS_W-1:0]   snap_ns;
    logic [DATA_W-1:0] hi_word;
    logic [DATA_W-1:0] rd_mux;

    assign wr = bus_en && bus_we;
    assign rd = bus_en && !bus_we;

    generate
        if (HI_W < DATA_W) begin : g_hi_pad
            assign hi_word = {{(DATA_W - HI_W){1'b0}}, snap_ns[NS_W-1:DATA_W]};
        end else begin : g_hi_full
            assign hi_word = snap_ns[NS_W-1:DATA_W];
        end
    endgenerate

    always_comb begin
        aux_wr   = wr && (bus_addr == RA_AUX);
        aux_halt = bus_wdata[DATA_W-1];
        load     = wr && (bus_addr == RA_NSHI);
        load_val = {bus_wdata[HI_W-1:0], stage_lo};
    end

    always_comb begin
        case (bus_addr)
            RA_TRIM:  rd_mux = trim;
            RA_AUX:   rd_mux = {halted, {(DATA_W-1){1'b0}}};
            RA_SUBNS: rd_mux = frac_acc;
            RA_NSLO:  rd_mux = snap_ns[DATA_W-1:0];
            RA_NSHI:  rd_mux = hi_word;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trim      <= '0;
            stage_lo  <= '0;
            snap_ns   <= '0;
            bus_rdata <= '0;
        end else begin
            if (wr) begin
                case (bus_addr)
                    RA_TRIM: trim     <= bus_wdata;
                    RA_NSLO: stage_lo <= bus_wdata;
                    default: ;
                endcase
            end
            if (rd) begin
                bus_rdata <= rd_mux;
                if (bus_addr == RA_SUBNS) begin
                    snap_ns <= ns_cnt;
                end
            end
        end
    end
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
    import ptp_tc_pkg::*;
#(
    parameter int unsigned NS_W     = 40,
    parameter int unsigned NOM_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NS_W-1:0]   cur_ns
);
    trim_t             trim_w;
    logic              aux_wr;
    logic              aux_halt;
    logic              load_w;
    logic [NS_W-1:0]   load_val;
    logic              tick_en;
    logic              halted;
    logic [FRAC_W-1:0] acc_w;

    ptp_tc_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .aux_wr   (aux_wr),
        .aux_halt (aux_halt),
        .tick_en  (tick_en),
        .halted   (halted)
    );

    ptp_tc_regbank #(
        .NS_W (NS_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ns_cnt    (cur_ns),
        .frac_acc  (acc_w),
        .halted    (halted),
        .trim      (trim_w),
        .aux_wr    (aux_wr),
        .aux_halt  (aux_halt),
        .load      (load_w),
        .load_val  (load_val)
    );

    ptp_tc_time_core #(
        .NS_W     (NS_W),
        .NOM_STEP (NOM_STEP)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load     (load_w),
        .load_val (load_val),
        .trim     (trim_w),
        .ns_cnt   (cur_ns),
        .frac_acc (acc_w)
    );
endmodule

// File: rtl/ptp_time_counter_chk.sv
module ptp_time_counter_chk
    import ptp_tc_pkg::*;
#(
    parameter int unsigned NS_W     = 40,
    parameter int unsigned NOM_STEP = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NS_W-1:0]   cur_ns,
    input logic [FRAC_W-1:0] frac_acc,
    input logic              tick_en,
    input logic              load,
    input logic [DATA_W-1:0] trim,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata
);
    localparam int unsigned HI_W = NS_W - DATA_W;

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load) |=> ($stable(cur_ns) && $stable(frac_acc)));

    // R3
    nominal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load && trim[MAG_W-1:0] == '0) |=>
        ((cur_ns - $past(cur_ns)) == NS_W'(NOM_STEP) && $stable(frac_acc)));

    // R4
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load && !trim[DATA_W-1]) |=>
        ((cur_ns - $past(cur_ns)) == NS_W'(NOM_STEP) ||
         (cur_ns - $past(cur_ns)) == NS_W'(NOM_STEP + 1)));

    // R5
    neg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load && trim[DATA_W-1]) |=>
        ((cur_ns - $past(cur_ns)) == NS_W'(NOM_STEP) ||
         (cur_ns - $past(cur_ns)) == NS_W'(NOM_STEP - 1)));

    // R7
    load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (frac_acc == '0));

    // R6
    hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == RA_NSHI) |=>
        ((bus_rdata >> HI_W) == '0));

    // R9
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr > RA_NSHI) |=> (bus_rdata == '0));
endmodule

bind ptp_time_counter ptp_time_counter_chk #(
    .NS_W     (NS_W),
    .NOM_STEP (NOM_STEP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_ns    (cur_ns),
    .frac_acc  (acc_w),
    .tick_en   (tick_en),
    .load      (load_w),
    .trim      (trim_w),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/tb_ptp_time_counter.sv
module tb_ptp_time_counter;
    localparam int CLK_PERIOD = 8;
    localparam int NS_W = 40;
    localparam longint unsigned NS_MASK = (64'd1 << NS_W) - 64'd1;
    localparam longint unsigned TWO32   = 64'h1_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NS_W-1:0] cur_ns;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_time_counter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cur_ns    (cur_ns)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural reference
    longint unsigned m_ns, m_acc, m_adj, m_lo, m_snap, m_rd, mag, st;
    bit m_halt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ns = 0; m_acc = 0; m_adj = 0; m_lo = 0; m_snap = 0; m_rd = 0;
            m_halt = 1'b1;
        end else begin
            if (bus_en && !bus_we) begin
                case (bus_addr)
                    3'd0: m_rd = m_adj;
                    3'd1: m_rd = m_halt ? 64'h8000_0000 : 64'd0;
                    3'd2: begin m_rd = m_acc; m_snap = m_ns; end
                    3'd3: m_rd = m_snap & 64'hFFFF_FFFF;
                    3'd4: m_rd = m_snap >> 32;
                    default: m_rd = 0;
                endcase
            end
            if (!m_halt) begin
                mag = m_adj & 64'h7FFF_FFFF;
                st = 8;
                if (((m_adj >> 31) & 1) == 1) begin
                    if (m_acc < mag) begin m_acc = m_acc + TWO32 - mag; st = 7; end
                    else m_acc = m_acc - mag;
                end else begin
                    m_acc = m_acc + mag;
                    if (m_acc >= TWO32) begin m_acc = m_acc - TWO32; st = 9; end
                end
                m_ns = (m_ns + st) & NS_MASK;
            end
            if (bus_en && bus_we) begin
                case (bus_addr)
                    3'd0: m_adj = 64'(bus_wdata);
                    3'd1: m_halt = bus_wdata[31];
                    3'd3: m_lo = 64'(bus_wdata);
                    3'd4: begin
                        m_ns = (64'(bus_wdata[7:0]) << 32) | m_lo;
                        m_acc = 0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks += 2;
            if (64'(cur_ns) !== m_ns) begin
                errors++;
                $display("FAIL %s cur_ns act %h exp %h", cur_req, cur_ns, m_ns);
            end
            if (64'(bus_rdata) !== m_rd) begin
                errors++;
                $display("FAIL %s rdata act %h exp %h", cur_req, bus_rdata, m_rd);
            end
        end
    end

    task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        longint unsigned t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        rd(3'd1, v); chk("R1 aux reset", 64'(v), 64'h8000_0000);
        rd(3'd0, v); chk("R1 trim reset", 64'(v), 0);
        rd(3'd2, v); chk("R1 subns reset", 64'(v), 0);
        rd(3'd3, v); chk("R1 nslo reset", 64'(v), 0);
        rd(3'd4, v); chk("R1 nshi reset", 64'(v), 0);

        cur_req = "R2";
        repeat (20) @(negedge clk);
        chk("R2 halted count", 64'(cur_ns), 0);

        cur_req = "R7";
        wr(3'd3, 32'h1234_5678);
        wr(3'd4, 32'hFFFF_FFAB);
        chk("R7 load halted", 64'(cur_ns), 64'hAB_1234_5678);
        rd(3'd2, v); chk("R7 subns clear", 64'(v), 0);
        rd(3'd3, v); chk("R7 nslo", 64'(v), 64'h1234_5678);
        rd(3'd4, v); chk("R6 nshi padded", 64'(v), 64'hAB);

        cur_req = "R3";
        wr(3'd1, 32'h0);
        t0 = 64'(cur_ns);
        repeat (10) @(negedge clk);
        chk("R3 ten ticks", (64'(cur_ns) - t0) & NS_MASK, 80);
        rd(3'd1, v); chk("R2 running aux", 64'(v), 0);

        cur_req = "R10";
        wr(3'd0, 32'h4000_0000);
        rd(3'd0, v); chk("R10 trim readback", 64'(v), 64'h4000_0000);

        cur_req = "R4";
        t0 = 64'(cur_ns);
        repeat (8) @(negedge clk);
        chk("R4 quarter ns gain", (64'(cur_ns) - t0) & NS_MASK, 66);
        for (int i = 0; i < 6; i++) rd(3'd2, v);
        wr(3'd0, 32'h7FFF_FFFF);
        for (int i = 0; i < 6; i++) rd(3'd2, v);

        cur_req = "R5";
        wr(3'd0, 32'hC000_0000);
        t0 = 64'(cur_ns);
        repeat (8) @(negedge clk);
        chk("R5 quarter ns loss", (64'(cur_ns) - t0) & NS_MASK, 62);
        wr(3'd0, 32'hFFFF_FFFF);
        for (int i = 0; i < 6; i++) rd(3'd2, v);

        cur_req = "R6";
        rd(3'd2, v);
        repeat (30) @(negedge clk);
        rd(3'd3, v);
        chk("R6 frozen lo", 64'(v), m_snap & 64'hFFFF_FFFF);
        chk("R6 not live", 64'(v != cur_ns[31:0]), 1);
        rd(3'd4, v);
        chk("R6 frozen hi", 64'(v), m_snap >> 32);

        cur_req = "R7";
        wr(3'd0, 32'h4000_0000);
        wr(3'd3, 32'h0000_1000);
        wr(3'd4, 32'h0000_0005);
        chk("R7 load running no tick", 64'(cur_ns), 64'h05_0000_1000);
        rd(3'd2, v);

        cur_req = "R8";
        wr(3'd1, 32'h8000_0000);
        wr(3'd0, 32'h0);
        wr(3'd3, 32'hFFFF_FFF0);
        wr(3'd4, 32'h0000_00FF);
        chk("R8 preload", 64'(cur_ns), 64'hFF_FFFF_FFF0);
        wr(3'd1, 32'h0);
        repeat (4) @(negedge clk);
        chk("R8 wrapped", 64'(cur_ns), 64'h10);

        cur_req = "R2";
        wr(3'd1, 32'h8000_0000);
        t0 = 64'(cur_ns);
        repeat (10) @(negedge clk);
        chk("R2 stop holds", 64'(cur_ns), t0);

        cur_req = "R9";
        wr(3'd2, 32'h0000_1234);
        rd(3'd2, v); chk("R9 subns write ignored", 64'(v), 0);
        wr(3'd6, 32'hFFFF_FFFF);
        chk("R9 unmapped write", 64'(cur_ns), t0);
        rd(3'd5, v); chk("R9 unmapped rd5", 64'(v), 0);
        rd(3'd7, v); chk("R9 unmapped rd7", 64'(v), 0);
        rd(3'd0, v); chk("R9 trim untouched", 64'(v), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog act timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule